// File: doc/BRIEF.md
# Saturating Vector Pack Unit

This block turns two vectors of wide integer lanes into one vector of half-width lanes. Each lane of both operands is clamped to the range of the narrower type. The narrowed lanes are then joined into a single result. Three conversions are provided: 16-bit signed lanes to signed bytes, 16-bit signed lanes to unsigned bytes, and 32-bit signed lanes to signed 16-bit words. Each conversion runs on either a 64-bit or a 128-bit vector.

The lanes are not interleaved. Every narrowed lane of the destination operand goes into the lower half of the result, and every narrowed lane of the source operand goes into the upper half. A caller raises `in_valid` together with the operation, the width mode and both operands. The result is registered and appears on the following clock with a one-cycle `out_valid` pulse. Between valid inputs the result register holds its value.

Top module: `vec_pack_sat`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` is 0 and `out_vec` is all zeros.
- R2: For an input accepted on a clock edge with `in_valid`=1, `out_valid` is 1 after that edge. It returns to 0 after the next edge unless `in_valid` is 1 again.
- R3: Lane i of the destination operand narrows into result lane i. Lane i of the source operand narrows into result lane n+i, where n is the number of lanes per operand. Lanes are numbered from bit 0 upwards.
- R4: `op_sel`=0 reads each 16-bit lane as two's complement and clamps it to -128..127, giving a byte.
- R5: `op_sel`=1 reads each 16-bit lane as two's complement. A negative lane gives 0x00, a lane above 255 gives 0xFF, and any other lane gives its low byte.
- R6: `op_sel`=2 reads each 32-bit lane as two's complement and clamps it to -32768..32767, giving a 16-bit word.
- R7: `wide_mode`=0 uses only bits 63:0 of each operand (four 16-bit or two 32-bit lanes each). The result fills bits 63:0, and bits 127:64 of the result are 0. Operand bits 127:64 have no effect. `wide_mode`=1 uses all 128 bits (eight or four lanes each).
- R8: `op_sel`=3 is reserved and produces an all-zero result.
- R9: While `in_valid` is 0, `out_vec` keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Inputs are valid this cycle |
| op_sel | input | 2 | 0 signed 16->8, 1 unsigned 16->8, 2 signed 32->16, 3 reserved |
| wide_mode | input | 1 | 1 = 128-bit vectors, 0 = 64-bit vectors |
| dst_vec | input | 128 | Destination operand; its lanes form the lower half of the result |
| src_vec | input | 128 | Source operand; its lanes form the upper half of the result |
| out_vec | output | 128 | Registered packed result |
| out_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench drives every lane with values that sit on or next to a clamp limit: 0x7FFF, 0x8000, 0x00FF, 0x0100, 0xFFFF, 0x007F, 0xFF80, and their 32-bit counterparts. Each set is rotated through all lanes, for every operation and both widths. A design that compared signed values as unsigned would turn 0x8000 into 0x7F instead of 0x80, or into 0xFF instead of 0x00 in unsigned mode. A design that tested only the bits above the output width, without checking the sign, would pass 0x00FF through unchanged in signed mode instead of clamping it to 0x7F. Garbage is placed in the upper operand halves in 64-bit mode, and inputs are scrambled while `in_valid` is low. This exposes a design that leaks unused lanes into the result, interleaves the two operands, or updates the result without a valid input.

// File: rtl/vec_pack_sat.sv
module vec_pack_sat #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op_sel,
  input  logic          wide_mode,
  input  logic [VW-1:0] dst_vec,
  input  logic [VW-1:0] src_vec,
  output logic [VW-1:0] out_vec,
  output logic          out_valid
);

  localparam int HALF  = VW / 2;
  localparam int NBYTE = VW / 8;
  localparam int NWRD  = VW / 16;

  function automatic logic [7:0] clamp_s8(input logic [15:0] w);
    if (!w[15] && (w[14:7] != 8'h00))      return 8'h7F;
    else if (w[15] && (w[14:7] != 8'hFF))  return 8'h80;
    else                                   return w[7:0];
  endfunction

  function automatic logic [7:0] clamp_u8(input logic [15:0] w);
    if (w[15])                 return 8'h00;
    else if (w[14:8] != 7'h0)  return 8'hFF;
    else                       return w[7:0];
  endfunction

  function automatic logic [15:0] clamp_s16(input logic [31:0] d);
    if (!d[31] && (d[30:15] != 16'h0000))      return 16'h7FFF;
    else if (d[31] && (d[30:15] != 16'hFFFF))  return 16'h8000;
    else                                       return d[15:0];
  endfunction

  logic [2*VW-1:0] joined;
  logic [VW-1:0]   res_sb, res_ub, res_sw, next_vec;

  assign joined = wide_mode ? {src_vec, dst_vec}
                            : {{VW{1'b0}}, src_vec[HALF-1:0], dst_vec[HALF-1:0]};

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign res_sb[8*i +: 8] = clamp_s8(joined[16*i +: 16]);
    assign res_ub[8*i +: 8] = clamp_u8(joined[16*i +: 16]);
  end

  for (genvar j = 0; j < NWRD; j++) begin : g_word
    assign res_sw[16*j +: 16] = clamp_s16(joined[32*j +: 32]);
  end

  always_comb begin
    case (op_sel)
      2'd0:    next_vec = res_sb;
      2'd1:    next_vec = res_ub;
      2'd2:    next_vec = res_sw;
      default: next_vec = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vec   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= next_vec;
    end
  end

  AST_PULSE_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(wide_mode)) |-> (out_vec[VW-1:HALF] == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec)); // R9
  AST_UNSIGNED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 2'd1 && $past(dst_vec[15])) |-> (out_vec[7:0] == 8'h00)); // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 2'd3) |-> (out_vec == '0)); // R8

endmodule

// File: tb/sim_vec_pack_sat.sv
module sim_vec_pack_sat;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op_sel = 2'd0;
  logic         wide_mode = 1'b0;
  logic [127:0] dst_vec = '0;
  logic [127:0] src_vec = '0;
  logic [127:0] out_vec;
  logic         out_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_pack_sat u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .wide_mode(wide_mode), .dst_vec(dst_vec), .src_vec(src_vec),
    .out_vec(out_vec), .out_valid(out_valid)
  );

  logic [15:0] wset [10] = '{16'h7FFF, 16'h8000, 16'h00FF, 16'h0100, 16'hFFFF,
                             16'h0000, 16'h007F, 16'hFF80, 16'h0080, 16'hFF7F};
  logic [31:0] dset [10] = '{32'h00007FFF, 32'h00008000, 32'hFFFF8000, 32'hFFFF7FFF,
                             32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h00000000,
                             32'h000000FF, 32'h00010000};

  function automatic logic [7:0] nb(int op, logic [15:0] w);
    int v = $signed(w);
    if (op == 0) v = (v > 127) ? 127 : (v < -128) ? -128 : v;
    else         v = (v < 0) ? 0 : (v > 255) ? 255 : v;
    return v[7:0];
  endfunction

  function automatic logic [15:0] nw(logic [31:0] d);
    longint v = $signed(d);
    v = (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
    return v[15:0];
  endfunction

  function automatic logic [127:0] model(int op, bit wide, logic [127:0] d, logic [127:0] s);
    logic [127:0] r = '0;
    int n;
    if (op == 3) return r;
    if (op < 2) begin
      n = wide ? 8 : 4;
      for (int i = 0; i < n; i++) begin
        r[8*i +: 8]     = nb(op, d[16*i +: 16]);
        r[8*(n+i) +: 8] = nb(op, s[16*i +: 16]);
      end
    end else begin
      n = wide ? 4 : 2;
      for (int i = 0; i < n; i++) begin
        r[16*i +: 16]     = nw(d[32*i +: 32]);
        r[16*(n+i) +: 16] = nw(s[32*i +: 32]);
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int op, bit wide);
    string t;
    case (op)
      0: t = "R4/R3";
      1: t = "R5/R3";
      2: t = "R6/R3";
      default: t = "R8";
    endcase
    if (!wide) t = {t, "/R7"};
    return t;
  endfunction

  task automatic run(int op, bit wide, logic [127:0] d, logic [127:0] s);
    logic [127:0] exp = model(op, wide, d, s);
    @(negedge clk);
    op_sel = op[1:0]; wide_mode = wide; dst_vec = d; src_vec = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R2 valid", {127'b0, out_valid}, 128'd1);
    check(out_vec === exp, tag_of(op, wide), out_vec, exp);
    dst_vec = ~d; src_vec = {s[63:0], s[127:64]}; op_sel = ~op[1:0]; wide_mode = ~wide;
    @(negedge clk);
    check(out_valid === 1'b0, "R2 pulse", {127'b0, out_valid}, 128'd0);
    check(out_vec === exp, "R9 hold", out_vec, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 valid", {127'b0, out_valid}, 128'd0);
    check(out_vec === '0, "R1 data", out_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_vec === '0, "R1 after", out_vec, '0);

    for (int op = 0; op < 4; op++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 10; k++) begin
          logic [127:0] d, s;
          if (op == 2) begin
            for (int i = 0; i < 4; i++) begin
              d[32*i +: 32] = dset[(i + k) % 10];
              s[32*i +: 32] = dset[(i + k + 3) % 10];
            end
          end else begin
            for (int i = 0; i < 8; i++) begin
              d[16*i +: 16] = wset[(i + k) % 10];
              s[16*i +: 16] = wset[(i + k + 3) % 10];
            end
          end
          if (w == 0) begin
            d[127:64] = {4{16'h7FFF}};
            s[127:64] = {4{16'h8000}};
          end
          run(op, w[0], d, s);
        end

    for (int n = 0; n < 300; n++) begin
      logic [127:0] d, s;
      d = {$urandom, $urandom, $urandom, $urandom};
      s = {$urandom, $urandom, $urandom, $urandom};
      run(n % 4, n[2], d, s);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule